// File: doc/BRIEF.md
# Protection Key Rights Register Unit

This unit holds the 32-bit access-rights word that a 64-bit CPU core consults when it applies per-page protection keys. It serves the two instructions that read and write that word. It also serves the restore and save steps of the extended processor-state area. Instruction decode, the memory accesses behind save and restore, and the rest of the extended-state logic sit outside the unit. They present one request at a time on the ports below.

Each read or write request is checked before it takes effect. The unit raises an invalid-opcode indication if the feature is not enabled in the control register, or if the instruction carried a lock prefix. Otherwise it raises a general-protection indication if the selector operand is non-zero, or if a write's upper half is non-zero. A request that passes these checks either returns the register or loads it. Cached address translations depend on the rights word, so the unit emits a flush pulse on every successful write, and on a restore only when the restore changes the register.

Top module: `prot_key_unit`

## Requirements
- R1: After reset the rights register reads zero and every pulse output (invalid-opcode, general-protection, read-valid, save-valid, flush) is low.
- R2: A read or write request with `keyEnable` low or `lockPrefix` high raises `excInvalidOp` for one cycle, leaves the register unchanged, produces no read data and no flush.
- R3: A read or write request that passes the R2 check but has a non-zero `selector` raises `excGenProt`, leaves the register unchanged and gives no flush. When both checks fail, only `excInvalidOp` is raised, because invalid-opcode has priority and at most one exception is signalled per request.
- R4: A write that passes the R2 and R3 checks but has a non-zero `wrHi` raises `excGenProt` and does not update the register or flush.
- R5: A successful read pulses `rdValid`, returns the register on `rdLo` and zero on `rdHi`.
- R6: A successful write loads `wrLo` into the register and pulses `flushTlb`, even when the value is unchanged.
- R7: A restore (`rstrReq`) with `rstrFeature` high and `rstrHeader` high loads `rstrData` into the register.
- R8: A restore with `rstrFeature` high and `rstrHeader` low clears the register to zero.
- R9: A restore pulses `flushTlb` only if the new register value differs from the old one.
- R10: A restore with `rstrFeature` low leaves the register unchanged and gives no flush.
- R11: A save (`saveReq`) with `saveFeature` high pulses `saveValid` and presents the register zero-extended to 64 bits on `saveData`. With `saveFeature` low, `saveValid` stays low.
- R12: All indications are registered and appear in the cycle after the request. Each lasts one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| keyEnable | input | 1 | Feature enable bit from the control register |
| lockPrefix | input | 1 | Request carried a lock prefix |
| rdReq | input | 1 | Read-rights instruction request |
| wrReq | input | 1 | Write-rights instruction request |
| selector | input | 32 | Selector operand, must be zero |
| wrLo | input | 32 | Low half of the 64-bit write operand |
| wrHi | input | 32 | High half of the 64-bit write operand |
| rstrReq | input | 1 | Extended-state restore step |
| rstrFeature | input | 1 | Component requested in the restore mask |
| rstrHeader | input | 1 | Component present in the save-area header |
| rstrData | input | 32 | Component word read from the save area |
| saveReq | input | 1 | Extended-state save step |
| saveFeature | input | 1 | Component selected for saving |
| rightsValue | output | 32 | Current rights register |
| rdValid | output | 1 | Read result valid pulse |
| rdLo | output | 32 | Read result, low half |
| rdHi | output | 32 | Read result, high half (zero) |
| excInvalidOp | output | 1 | Invalid-opcode exception pulse |
| excGenProt | output | 1 | General-protection exception pulse |
| flushTlb | output | 1 | Translation-cache flush pulse |
| saveValid | output | 1 | Save data valid pulse |
| saveData | output | 64 | Register value to store in the save area |

## Verification
Every result of this unit is due exactly one clock after the edge that samples the request. This holds for the exception pulses, the read data, the save data, the flush and the new register value. The driver applies one request per cycle on the falling edge and queues the full expected output vector for that request. The monitor wakes 2 ns after the next rising edge and pops one vector per cycle. Each comparison therefore sits in the cycle where the registered outputs have settled. Idle cycles also queue vectors, so a pulse that lasts one cycle too long is caught.

// File: rtl/pkey_pkg.sv
package pkey_pkg;

  // Strobes from the request checker to the rights datapath.
  typedef struct packed {
    logic loadWrite;    // checked write accepted
    logic loadRestore;  // restore of the component requested
    logic restoreHit;   // component present in header: take restore data
    logic readOut;      // checked read accepted
    logic saveOut;      // save of the component requested
  } keyStrobe_t;

endpackage

// File: rtl/pkey_ctrl.sv
module pkey_ctrl
  import pkey_pkg::*;
#(
  parameter int SEL_W  = 32,
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              keyEnable,
  input  logic              lockPrefix,
  input  logic              rdReq,
  input  logic              wrReq,
  input  logic [SEL_W-1:0]  selector,
  input  logic [HALF_W-1:0] wrHi,
  input  logic              rstrReq,
  input  logic              rstrFeature,
  input  logic              rstrHeader,
  input  logic              saveReq,
  input  logic              saveFeature,
  output keyStrobe_t        strb,
  output logic              excInvalidOp,
  output logic              excGenProt
);

  logic isAccess;
  logic udHit;
  logic gpHit;
  logic accessOk;

  // Invalid-opcode check first; general-protection only if it passes.
  always_comb begin
    isAccess = rdReq | wrReq;
    udHit    = isAccess & (lockPrefix | ~keyEnable);
    gpHit    = isAccess & ~udHit &
               ((selector != '0) | (wrReq & (wrHi != '0)));
    accessOk = isAccess & ~udHit & ~gpHit;

    strb.loadWrite   = accessOk & wrReq;
    strb.readOut     = accessOk & rdReq & ~wrReq;
    strb.loadRestore = rstrReq & rstrFeature;
    strb.restoreHit  = rstrHeader;
    strb.saveOut     = saveReq & saveFeature;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      excInvalidOp <= 1'b0;
      excGenProt   <= 1'b0;
    end else begin
      excInvalidOp <= udHit;
      excGenProt   <= gpHit;
    end
  end

  assert_ud_on_disabled_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((rdReq || wrReq) && (!keyEnable || lockPrefix)) |=> (excInvalidOp && !excGenProt));

  assert_gp_on_selector_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((rdReq || wrReq) && keyEnable && !lockPrefix && (selector != '0)) |=> excGenProt);

  assert_gp_on_high_half_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && !rdReq && keyEnable && !lockPrefix && (wrHi != '0)) |=> (excGenProt && !excInvalidOp));

  assert_one_exception_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(excInvalidOp && excGenProt));

  assert_one_request_R12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rdReq, wrReq, rstrReq, saveReq}));

endmodule

// File: rtl/pkey_data.sv
module pkey_data
  import pkey_pkg::*;
#(
  parameter int KEY_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  keyStrobe_t         strb,
  input  logic [KEY_W-1:0]   wrLo,
  input  logic [KEY_W-1:0]   rstrData,
  output logic [KEY_W-1:0]   keyReg,
  output logic               rdValid,
  output logic [KEY_W-1:0]   rdLo,
  output logic               saveValid,
  output logic [2*KEY_W-1:0] saveData,
  output logic               flushTlb
);

  localparam int WIDE_W = 2 * KEY_W;

  logic [KEY_W-1:0] nextVal;
  logic             flushNext;

  always_comb begin
    nextVal   = keyReg;
    flushNext = 1'b0;
    if (strb.loadWrite) begin
      nextVal   = wrLo;
      flushNext = 1'b1;              // write always flushes
    end else if (strb.loadRestore) begin
      nextVal   = strb.restoreHit ? rstrData : '0;
      flushNext = (nextVal != keyReg); // restore flushes only on change
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyReg    <= '0;
      rdValid   <= 1'b0;
      rdLo      <= '0;
      saveValid <= 1'b0;
      saveData  <= '0;
      flushTlb  <= 1'b0;
    end else begin
      keyReg    <= nextVal;
      flushTlb  <= flushNext;
      rdValid   <= strb.readOut;
      saveValid <= strb.saveOut;
      if (strb.readOut) rdLo <= keyReg;
      if (strb.saveOut) saveData <= {{(WIDE_W-KEY_W){1'b0}}, keyReg};
    end
  end

  assert_write_loads_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadWrite |=> (keyReg == $past(wrLo)) && flushTlb);

  assert_hold_without_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.loadWrite || strb.loadRestore) |=> ($stable(keyReg) && !flushTlb));

  assert_restore_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadRestore && !strb.restoreHit && !strb.loadWrite) |=> (keyReg == '0));

  assert_restore_flush_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadRestore && !strb.loadWrite) |=> (flushTlb == (keyReg != $past(keyReg))));

endmodule

// File: rtl/prot_key_unit.sv
module prot_key_unit
  import pkey_pkg::*;
#(
  parameter int KEY_W = 32,
  parameter int SEL_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               keyEnable,
  input  logic               lockPrefix,
  input  logic               rdReq,
  input  logic               wrReq,
  input  logic [SEL_W-1:0]   selector,
  input  logic [KEY_W-1:0]   wrLo,
  input  logic [KEY_W-1:0]   wrHi,
  input  logic               rstrReq,
  input  logic               rstrFeature,
  input  logic               rstrHeader,
  input  logic [KEY_W-1:0]   rstrData,
  input  logic               saveReq,
  input  logic               saveFeature,
  output logic [KEY_W-1:0]   rightsValue,
  output logic               rdValid,
  output logic [KEY_W-1:0]   rdLo,
  output logic [KEY_W-1:0]   rdHi,
  output logic               excInvalidOp,
  output logic               excGenProt,
  output logic               flushTlb,
  output logic               saveValid,
  output logic [2*KEY_W-1:0] saveData
);

  keyStrobe_t strb;

  pkey_ctrl #(.SEL_W(SEL_W), .HALF_W(KEY_W)) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .keyEnable   (keyEnable),
    .lockPrefix  (lockPrefix),
    .rdReq       (rdReq),
    .wrReq       (wrReq),
    .selector    (selector),
    .wrHi        (wrHi),
    .rstrReq     (rstrReq),
    .rstrFeature (rstrFeature),
    .rstrHeader  (rstrHeader),
    .saveReq     (saveReq),
    .saveFeature (saveFeature),
    .strb        (strb),
    .excInvalidOp(excInvalidOp),
    .excGenProt  (excGenProt)
  );

  pkey_data #(.KEY_W(KEY_W)) i_data (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrLo     (wrLo),
    .rstrData (rstrData),
    .keyReg   (rightsValue),
    .rdValid  (rdValid),
    .rdLo     (rdLo),
    .saveValid(saveValid),
    .saveData (saveData),
    .flushTlb (flushTlb)
  );

  // The register is 32 bits wide, so the upper half of a read is zero (R5).
  assign rdHi = '0;

endmodule

// File: tb/test_prot_key_unit.sv
module test_prot_key_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        keyEnable = 1'b0, lockPrefix = 1'b0, rdReq = 1'b0, wrReq = 1'b0;
  logic [31:0] selector = '0, wrLo = '0, wrHi = '0, rstrData = '0;
  logic        rstrReq = 1'b0, rstrFeature = 1'b0, rstrHeader = 1'b0;
  logic        saveReq = 1'b0, saveFeature = 1'b0;
  logic [31:0] rightsValue, rdLo, rdHi;
  logic        rdValid, excInvalidOp, excGenProt, flushTlb, saveValid;
  logic [63:0] saveData;

  always #4 clk = ~clk;  // 125 MHz

  prot_key_unit i_prot_key_unit (
    .clk(clk), .rstN(rstN), .keyEnable(keyEnable), .lockPrefix(lockPrefix),
    .rdReq(rdReq), .wrReq(wrReq), .selector(selector), .wrLo(wrLo), .wrHi(wrHi),
    .rstrReq(rstrReq), .rstrFeature(rstrFeature), .rstrHeader(rstrHeader),
    .rstrData(rstrData), .saveReq(saveReq), .saveFeature(saveFeature),
    .rightsValue(rightsValue), .rdValid(rdValid), .rdLo(rdLo), .rdHi(rdHi),
    .excInvalidOp(excInvalidOp), .excGenProt(excGenProt), .flushTlb(flushTlb),
    .saveValid(saveValid), .saveData(saveData)
  );

  typedef struct packed {
    logic        ud;
    logic        gp;
    logic        rdV;
    logic [31:0] rdData;
    logic        sV;
    logic [63:0] sData;
    logic        flush;
    logic [31:0] val;
  } expItem_t;

  expItem_t expQ[$];
  string    tagQ[$];
  int       nChecks = 0;
  int       nFails = 0;
  logic [31:0] model = '0;
  logic     monOn = 1'b0;
  logic     done = 1'b0;

  // Driver core: apply one request at the falling edge and queue its expectation.
  task automatic step(input logic rd, input logic wr, input logic en, input logic lk,
                      input logic [31:0] sel, input logic [31:0] lo, input logic [31:0] hi,
                      input logic rs, input logic rf, input logic rh, input logic [31:0] rdat,
                      input logic sv, input logic sf, input string tag);
    expItem_t e;
    logic udE, gpE, okE;
    logic [31:0] nv;
    @(negedge clk);
    rdReq = rd; wrReq = wr; keyEnable = en; lockPrefix = lk; selector = sel;
    wrLo = lo; wrHi = hi; rstrReq = rs; rstrFeature = rf; rstrHeader = rh;
    rstrData = rdat; saveReq = sv; saveFeature = sf;
    udE = (rd || wr) && (lk || !en);
    gpE = (rd || wr) && !udE && ((sel != 0) || (wr && hi != 0));
    okE = (rd || wr) && !udE && !gpE;
    e = '0;
    e.ud = udE; e.gp = gpE;
    e.rdV = okE && rd; e.rdData = model;
    e.sV = sv && sf; e.sData = {32'h0, model};
    nv = model;
    if (okE && wr) begin
      nv = lo; e.flush = 1'b1;
    end else if (rs && rf) begin
      nv = rh ? rdat : 32'h0;
      e.flush = (nv != model);
    end
    e.val = nv;
    model = nv;
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic doWrite(input logic en, input logic lk, input logic [31:0] sel,
                         input logic [31:0] hi, input logic [31:0] lo, input string tag);
    step(1'b0, 1'b1, en, lk, sel, lo, hi, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, tag);
  endtask
  task automatic doRead(input logic en, input logic lk, input logic [31:0] sel, input string tag);
    step(1'b1, 1'b0, en, lk, sel, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, tag);
  endtask
  task automatic doRestore(input logic rf, input logic rh, input logic [31:0] d, input string tag);
    step(1'b0, 1'b0, 1'b1, 1'b0, 32'h0, 32'h0, 32'h0, 1'b1, rf, rh, d, 1'b0, 1'b0, tag);
  endtask
  task automatic doSave(input logic sf, input string tag);
    step(1'b0, 1'b0, 1'b1, 1'b0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 32'h0, 1'b1, sf, tag);
  endtask
  task automatic doIdle(input string tag);
    step(1'b0, 1'b0, 1'b1, 1'b0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, tag);
  endtask

  // Monitor: 2 ns after each rising edge, compare the outputs with the queued vector.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (monOn && expQ.size() > 0) begin
        expItem_t e;
        string t;
        logic bad;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        nChecks++;
        bad = (excInvalidOp !== e.ud) || (excGenProt !== e.gp) || (rdValid !== e.rdV) ||
              (saveValid !== e.sV) || (flushTlb !== e.flush) || (rightsValue !== e.val) ||
              (e.rdV && (rdLo !== e.rdData || rdHi !== 32'h0)) ||
              (e.sV && saveData !== e.sData);
        if (bad) begin
          nFails++;
          $display("FAIL %s: got ud=%b gp=%b rdv=%b rd=%h_%h sv=%b sd=%h fl=%b val=%h ; exp ud=%b gp=%b rdv=%b rd=00000000_%h sv=%b sd=%h fl=%b val=%h",
                   t, excInvalidOp, excGenProt, rdValid, rdHi, rdLo, saveValid, saveData,
                   flushTlb, rightsValue, e.ud, e.gp, e.rdV, e.rdData, e.sV, e.sData,
                   e.flush, e.val);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1: state while held in reset
    nChecks++;
    if (rightsValue !== 32'h0 || excInvalidOp || excGenProt || rdValid || saveValid || flushTlb) begin
      nFails++;
      $display("FAIL R1 reset: got val=%h pulses=%b%b%b%b%b, expected 0", rightsValue,
               excInvalidOp, excGenProt, rdValid, saveValid, flushTlb);
    end
    @(negedge clk);
    rstN = 1'b1;
    monOn = 1'b1;
    doIdle("R1 after reset");
    doRead(1'b1, 1'b0, 32'h0, "R1 R5 read zero after reset");

    doWrite(1'b1, 1'b0, 32'h0, 32'h0, 32'h0000_000C, "R6 write");
    doRead(1'b1, 1'b0, 32'h0, "R5 read back");
    doWrite(1'b1, 1'b0, 32'h0, 32'h0, 32'h0000_000C, "R6 same value still flushes");
    doIdle("R12 pulses drop");

    doWrite(1'b0, 1'b0, 32'h0, 32'h0, 32'hDEAD_BEEF, "R2 write disabled");
    doRead(1'b0, 1'b0, 32'h0, "R2 read disabled");
    doWrite(1'b1, 1'b1, 32'h0, 32'h0, 32'h1111_1111, "R2 write lock prefix");
    doRead(1'b1, 1'b1, 32'h0, "R2 read lock prefix");
    doRead(1'b1, 1'b0, 32'h0, "R2 register held");

    doWrite(1'b1, 1'b0, 32'h1, 32'h0, 32'h2222_2222, "R3 write selector");
    doRead(1'b1, 1'b0, 32'h8000_0000, "R3 read selector");
    doWrite(1'b0, 1'b0, 32'h5, 32'h7, 32'h3333_3333, "R3 priority ud over gp");
    doRead(1'b1, 1'b1, 32'h9, "R3 priority lock over selector");

    doWrite(1'b1, 1'b0, 32'h0, 32'h0000_0001, 32'h0000_FFFF, "R4 high half set");
    doWrite(1'b1, 1'b0, 32'h0, 32'h8000_0000, 32'h0, "R4 top bit set");
    doRead(1'b1, 1'b0, 32'h0, "R4 register held");

    doRestore(1'b1, 1'b1, 32'h0000_0055, "R7 restore load");
    doRestore(1'b1, 1'b1, 32'h0000_0055, "R9 restore same no flush");
    doRestore(1'b1, 1'b0, 32'hFFFF_FFFF, "R8 restore absent zeroes");
    doRestore(1'b1, 1'b0, 32'h1234_5678, "R9 zero to zero no flush");
    doRestore(1'b1, 1'b1, 32'hA5A5_0F0F, "R7 R9 restore change");
    doRestore(1'b0, 1'b1, 32'h0000_00AA, "R10 not requested");
    doRestore(1'b0, 1'b0, 32'h0, "R10 not requested header clear");
    doRead(1'b1, 1'b0, 32'h0, "R10 register held");

    doSave(1'b1, "R11 save");
    doSave(1'b0, "R11 save not selected");
    doWrite(1'b1, 1'b0, 32'h0, 32'h0, 32'hFFFF_FFFF, "R6 write all ones");
    doSave(1'b1, "R11 save all ones");

    doWrite(1'b0, 1'b0, 32'h0, 32'h0, 32'h0, "R12 back to back ud");
    doWrite(1'b0, 1'b0, 32'h0, 32'h0, 32'h0, "R12 back to back ud");
    doIdle("R12 ud drops");
    doWrite(1'b1, 1'b0, 32'h0, 32'h0, 32'h0000_0003, "R12 write flush");
    doIdle("R12 flush drops");
    doIdle("R12 idle");

    while (expQ.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule